// File: doc/BRIEF.md
# Per-Bit Perceptron Weight Engine

This block is the learning core of a target predictor for indirect branches that works one address bit at a time. It keeps N independently indexed weight tables. Each row of a table holds K small signed weights, one for each low-order bit of a branch target. A lookup selects one row in every table and adds the weights position by position. The result is a vector of K confidence values: a large positive value says the bit is probably 1, a large negative value says it is probably 0. A later stage compares candidate targets against this vector and picks one.

The indices for tables 1 to N-1 are computed outside the block. Table 0 is indexed from a per-branch local history. That history lives in an internal table of 10-bit shift registers, selected by a slot number.

When a branch resolves, the caller returns the row indices and the confidence vector that were used for its prediction. With them come the actual target, a mask of bits to suppress and a flag that marks a whole-target mispredict. The block then adjusts every contributing weight toward the actual bit, saturating at the weight limits. A programmable threshold decides whether a bit that was predicted correctly still gets reinforced.

Top module: `perceptron_weight_engine`

## Requirements
- R1: The confidence vector and the row indices actually used appear on `pred_conf` and `pred_rows` with `pred_conf_valid` high in the cycle after `pred_valid` is sampled high. `pred_conf_valid` is low in the cycle after `pred_valid` is sampled low.
- R2: Weights are 4-bit sign/magnitude values: bit 3 is the sign, bits 2:0 are the magnitude. The range is -7 to +7, and negative zero is never stored. After reset every weight is zero, so every confidence element reads 0.
- R3: Confidence element k, on `pred_conf[8k+7:8k]`, is the 8-bit two's-complement sum of weight k taken from the selected row of each of the N tables. Table i>0 uses `pred_idx[(i-1)*5 +: 5]`.
- R4: When bit k is trained, each of the N weights that contributed to it is incremented if actual target bit k is 1, and decremented if it is 0. The rows used are the ones given on `upd_rows` (table i at bits `[i*5 +: 5]`).
- R5: Training saturates: a weight at +7 does not increase, and a weight at -7 does not decrease.
- R6: An unsuppressed bit k is trained when any of these holds: `upd_mispred` is 1; the sign of its returned confidence disagrees with the actual bit (a value of 0 or more predicts 1); or the magnitude of that confidence is below the threshold.
- R7: An unsuppressed bit that was predicted correctly, with a confidence magnitude at or above the threshold and `upd_mispred` low, leaves its weights unchanged.
- R8: A bit set in `upd_suppress` leaves its weights unchanged. A bit set in `pred_suppress` reads as confidence 0 in that prediction.
- R9: The threshold resets to 14. A pulse on `cfg_we` loads `cfg_theta`, and the threshold holds at all other times.
- R10: Table 0's row is the low 5 bits of the local history at slot `pred_lslot`. Every update, whatever its suppress mask, shifts actual target bit 3 into the least significant bit of the history at `upd_lslot`.
- R11: An update changes only the rows named on `upd_rows`. Rows read by predictions made in between are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the training threshold |
| cfg_theta | input | 8 | New threshold value |
| pred_valid | input | 1 | Lookup request |
| pred_idx | input | 35 | Row indices for tables 1..7, 5 bits each |
| pred_lslot | input | 8 | Local-history slot for the lookup |
| pred_suppress | input | 12 | Bits forced to confidence 0 |
| pred_conf_valid | output | 1 | Confidence vector valid |
| pred_conf | output | 96 | K signed 8-bit confidence elements |
| pred_rows | output | 40 | Row indices used, tables 0..7 |
| upd_valid | input | 1 | Training request |
| upd_rows | input | 40 | Rows captured at prediction time |
| upd_lslot | input | 8 | Local-history slot to shift |
| upd_target | input | 12 | Actual target low bits |
| upd_conf | input | 96 | Confidence vector used for that prediction |
| upd_suppress | input | 12 | Bits excluded from training |
| upd_mispred | input | 1 | Whole-target mispredict, forces training |

## Verification
A corrupted weight or a wrong training decision shows up on `pred_conf` in the very next lookup of the affected row, one cycle after that lookup is requested. The error appears as a sum that differs from the model by a multiple of one per table. A wrong local-history shift shows up as a wrong table-0 row on `pred_rows` at the next lookup of that slot. The bench keeps a full shadow of the weights and histories and compares every lookup against it. It also includes directed walks through saturation, the threshold boundary and the suppress masks.

// File: rtl/perceptron_weight_engine.sv
module perceptron_weight_engine #(
  parameter int N          = 8,
  parameter int K          = 12,
  parameter int ROW_W      = 5,
  parameter int LSLOT_W    = 8,
  parameter int LHIST_W    = 10,
  parameter int CONF_W     = 8,
  parameter int THETA_W    = 8,
  parameter int THETA_INIT = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [THETA_W-1:0]    cfg_theta,
  input  logic                  pred_valid,
  input  logic [(N-1)*ROW_W-1:0] pred_idx,
  input  logic [LSLOT_W-1:0]    pred_lslot,
  input  logic [K-1:0]          pred_suppress,
  output logic                  pred_conf_valid,
  output logic [K*CONF_W-1:0]   pred_conf,
  output logic [N*ROW_W-1:0]    pred_rows,
  input  logic                  upd_valid,
  input  logic [N*ROW_W-1:0]    upd_rows,
  input  logic [LSLOT_W-1:0]    upd_lslot,
  input  logic [K-1:0]          upd_target,
  input  logic [K*CONF_W-1:0]   upd_conf,
  input  logic [K-1:0]          upd_suppress,
  input  logic                  upd_mispred
);

  localparam int WW     = 4;
  localparam int WMAX   = 7;
  localparam int ROWS   = 1 << ROW_W;
  localparam int LSLOTS = 1 << LSLOT_W;
  localparam int LV     = $clog2(N);

  logic [K*WW-1:0]           wmem  [N][ROWS];
  logic [K*WW-1:0]           rd_q  [N];
  logic [N-1:0][K*WW-1:0]    wnew;
  logic [LHIST_W-1:0]        lhist [LSLOTS];
  logic [THETA_W-1:0]        theta_q;
  logic [K-1:0]              supp_q, train;
  logic [N*ROW_W-1:0]        rows_q, rd_row;
  logic                      vld_q;

  function automatic logic [CONF_W-1:0] sm_val(input logic [WW-1:0] w);
    logic [CONF_W-1:0] m;
    m = {{(CONF_W-WW+1){1'b0}}, w[WW-2:0]};
    return w[WW-1] ? -m : m;
  endfunction

  function automatic logic [WW-1:0] sm_step(input logic [WW-1:0] w, input logic up);
    int v;
    v = int'(w[WW-2:0]);
    if (w[WW-1]) v = -v;
    if (up && v < WMAX) v = v + 1;
    else if (!up && v > -WMAX) v = v - 1;
    return (v < 0) ? {1'b1, 3'(-v)} : {1'b0, 3'(v)};
  endfunction

  function automatic logic needs_train(input logic [CONF_W-1:0] c, input logic t,
                                       input logic s, input logic m,
                                       input logic [THETA_W-1:0] th);
    int v, a;
    v = int'($signed(c));
    a = (v < 0) ? -v : v;
    return !s && (m || ((v >= 0) != t) || (a < int'(th)));
  endfunction

  assign rd_row          = {pred_idx, lhist[pred_lslot][ROW_W-1:0]};
  assign pred_conf_valid = vld_q;
  assign pred_rows       = rows_q;

  genvar k, i, lv, j;
  generate
    for (k = 0; k < K; k++) begin : g_bit
      assign train[k] = needs_train(upd_conf[k*CONF_W +: CONF_W], upd_target[k],
                                    upd_suppress[k], upd_mispred, theta_q);

      for (i = 0; i < N; i++) begin : g_tab
        logic [WW-1:0] cur;
        assign cur = wmem[i][upd_rows[i*ROW_W +: ROW_W]][k*WW +: WW];
        assign wnew[i][k*WW +: WW] = train[k] ? sm_step(cur, upd_target[k]) : cur;

        AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
          pred_conf_valid |-> (rd_q[i][k*WW +: WW] != 4'b1000)); // R2
      end

      for (lv = 0; lv <= LV; lv++) begin : g_lv
        logic [(N>>lv)-1:0][CONF_W-1:0] s;
        for (j = 0; j < (N >> lv); j++) begin : g_n
          if (lv == 0) begin : g_leaf
            assign s[j] = sm_val(rd_q[j][k*WW +: WW]);
          end else begin : g_add
            assign s[j] = g_lv[lv-1].s[2*j] + g_lv[lv-1].s[2*j+1];
          end
        end
      end

      assign pred_conf[k*CONF_W +: CONF_W] = supp_q[k] ? '0 : g_lv[LV].s[0];

      AST_SUPP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && pred_suppress[k]) |=> (pred_conf[k*CONF_W +: CONF_W] == '0)); // R8
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      theta_q <= THETA_W'(THETA_INIT);
      vld_q   <= 1'b0;
      supp_q  <= '0;
      rows_q  <= '0;
      for (int t = 0; t < N; t++) begin
        rd_q[t] <= '0;
        for (int r = 0; r < ROWS; r++) wmem[t][r] <= '0;
      end
      for (int s = 0; s < LSLOTS; s++) lhist[s] <= '0;
    end else begin
      if (cfg_we) theta_q <= cfg_theta;
      vld_q <= pred_valid;
      if (pred_valid) begin
        supp_q <= pred_suppress;
        rows_q <= rd_row;
        for (int t = 0; t < N; t++) rd_q[t] <= wmem[t][rd_row[t*ROW_W +: ROW_W]];
      end
      if (upd_valid) begin
        for (int t = 0; t < N; t++) wmem[t][upd_rows[t*ROW_W +: ROW_W]] <= wnew[t];
        lhist[upd_lslot] <= {lhist[upd_lslot][LHIST_W-2:0], upd_target[3]};
      end
    end
  end

  AST_CONF_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |=> pred_conf_valid); // R1
  AST_CONF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |=> !pred_conf_valid); // R1
  AST_THETA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(theta_q)); // R9
  AST_LHIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (lhist[$past(upd_lslot)][0] == $past(upd_target[3]))); // R10

endmodule

// File: tb/test_perceptron_weight_engine.sv
module test_perceptron_weight_engine;
  localparam int N = 8, K = 12, ROW_W = 5, CW = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [7:0] cfg_theta = 0;
  logic pred_valid = 0; logic [(N-1)*ROW_W-1:0] pred_idx = 0;
  logic [7:0] pred_lslot = 0; logic [K-1:0] pred_suppress = 0;
  logic pred_conf_valid; logic [K*CW-1:0] pred_conf; logic [N*ROW_W-1:0] pred_rows;
  logic upd_valid = 0; logic [N*ROW_W-1:0] upd_rows = 0; logic [7:0] upd_lslot = 0;
  logic [K-1:0] upd_target = 0; logic [K*CW-1:0] upd_conf = 0;
  logic [K-1:0] upd_suppress = 0; logic upd_mispred = 0;

  perceptron_weight_engine i_perceptron_weight_engine (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, mtheta = 14;
  int wm [N][32][K];
  int lh [256];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic mreset();
    for (int i = 0; i < N; i++) for (int r = 0; r < 32; r++) for (int k = 0; k < K; k++) wm[i][r][k] = 0;
    for (int s = 0; s < 256; s++) lh[s] = 0;
    mtheta = 14;
  endtask

  function automatic int elem(input logic [K*CW-1:0] v, input int k);
    return int'($signed(v[k*CW +: CW]));
  endfunction

  function automatic logic [K*CW-1:0] mconf(input logic [N*ROW_W-1:0] r, input logic [K-1:0] s);
    logic [K*CW-1:0] v;
    for (int k = 0; k < K; k++) begin
      int sum = 0;
      for (int i = 0; i < N; i++) sum += wm[i][r[i*ROW_W +: ROW_W]][k];
      v[k*CW +: CW] = s[k] ? 8'd0 : 8'(sum);
    end
    return v;
  endfunction

  function automatic logic [(N-1)*ROW_W-1:0] rep(input int r);
    logic [(N-1)*ROW_W-1:0] v;
    for (int i = 0; i < N-1; i++) v[i*ROW_W +: ROW_W] = 5'(r);
    return v;
  endfunction

  function automatic logic [K*CW-1:0] pat(input int hi, input int lo, input logic [K-1:0] m);
    logic [K*CW-1:0] v;
    for (int k = 0; k < K; k++) v[k*CW +: CW] = m[k] ? 8'(hi) : 8'(lo);
    return v;
  endfunction

  task automatic pred(input logic [(N-1)*ROW_W-1:0] idx, input int slot, input logic [K-1:0] supp,
                      input string tag, output logic [K*CW-1:0] c, output logic [N*ROW_W-1:0] r);
    logic [N*ROW_W-1:0] er;
    er = {idx, 5'(lh[slot])};
    @(negedge clk);
    pred_valid = 1; pred_idx = idx; pred_lslot = 8'(slot); pred_suppress = supp;
    @(negedge clk);
    pred_valid = 0;
    c = pred_conf; r = pred_rows;
    chk(pred_conf_valid == 1'b1, "R1", "conf valid after request", 128'(pred_conf_valid), 128'(1));
    chk(r == er, tag, "rows used", 128'(r), 128'(er));
    chk(c == mconf(er, supp), tag, "confidence vector", 128'(c), 128'(mconf(er, supp)));
  endtask

  task automatic upd(input logic [N*ROW_W-1:0] r, input int slot, input logic [K-1:0] t,
                     input logic [K*CW-1:0] c, input logic [K-1:0] s, input bit m);
    @(negedge clk);
    upd_valid = 1; upd_rows = r; upd_lslot = 8'(slot); upd_target = t;
    upd_conf = c; upd_suppress = s; upd_mispred = m;
    @(negedge clk);
    upd_valid = 0;
    for (int k = 0; k < K; k++) begin
      int v = elem(c, k);
      int a = (v < 0) ? -v : v;
      if (!s[k] && (m || ((v >= 0) != t[k]) || a < mtheta))
        for (int i = 0; i < N; i++) begin
          int row = int'(r[i*ROW_W +: ROW_W]);
          if (t[k]) begin if (wm[i][row][k] < 7) wm[i][row][k]++; end
          else begin if (wm[i][row][k] > -7) wm[i][row][k]--; end
        end
    end
    lh[slot] = ((lh[slot] << 1) | int'(t[3])) & 1023;
  endtask

  task automatic step(input int rr, input int ps, input int us, input logic [K-1:0] t,
                      input logic [K-1:0] s, input bit m);
    logic [K*CW-1:0] c; logic [N*ROW_W-1:0] r;
    pred(rep(rr), ps, '0, "R3", c, r);
    upd(r, us, t, c, s, m);
  endtask

  task automatic set_theta(input int v);
    @(negedge clk); cfg_we = 1; cfg_theta = 8'(v);
    @(negedge clk); cfg_we = 0; mtheta = v;
  endtask

  initial begin
    logic [K*CW-1:0] c, ca, cb; logic [N*ROW_W-1:0] r, ra, rb;
    void'($urandom(32'h1b2c));
    mreset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    pred(rep(3), 5, '0, "R2", c, r);
    chk(c == '0, "R2", "reset confidence zero", 128'(c), 0);
    @(negedge clk);
    chk(pred_conf_valid == 1'b0, "R1", "valid drops when idle", 128'(pred_conf_valid), 0);

    repeat (3) step(0, 5, 200, 12'hFFF, '0, 1);
    pred(rep(0), 5, '0, "R4", c, r);
    chk(c == pat(24, 24, '1), "R4", "three raises give 24", 128'(c), 128'(pat(24, 24, '1)));
    step(0, 5, 200, 12'h00A, '0, 1);
    pred(rep(0), 5, '0, "R4", c, r);
    chk(c == pat(32, 16, 12'h00A), "R4", "3333 to 2424", 128'(c), 128'(pat(32, 16, 12'h00A)));
    step(0, 5, 200, 12'h00A, '0, 1);
    pred(rep(0), 5, '0, "R4", c, r);
    chk(c == pat(40, 8, 12'h00A), "R4", "2424 to 1515", 128'(c), 128'(pat(40, 8, 12'h00A)));

    repeat (10) step(0, 5, 200, 12'hFFF, '0, 1);
    pred(rep(0), 5, '0, "R5", c, r);
    chk(c == pat(56, 56, '1), "R5", "upper saturation", 128'(c), 128'(pat(56, 56, '1)));
    step(0, 5, 200, 12'hFFF, '0, 1);
    pred(rep(0), 5, '0, "R5", c, r);
    chk(c == pat(56, 56, '1), "R5", "stays at upper limit", 128'(c), 128'(pat(56, 56, '1)));
    repeat (16) step(0, 5, 200, 12'h000, '0, 1);
    pred(rep(0), 5, '0, "R5", c, r);
    chk(c == pat(-56, -56, '1), "R5", "lower saturation", 128'(c), 128'(pat(-56, -56, '1)));

    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    mreset();
    pred(rep(0), 5, '0, "R2", c, r);
    chk(c == '0, "R2", "zero after second reset", 128'(c), 0);

    step(0, 5, 200, 12'hFFF, '0, 1);
    step(0, 5, 200, 12'hFFF, '0, 0);
    pred(rep(0), 5, '0, "R9", c, r);
    chk(c == pat(16, 16, '1), "R9", "8 below reset threshold trains", 128'(c), 128'(pat(16, 16, '1)));
    step(0, 5, 200, 12'hFFF, '0, 0);
    pred(rep(0), 5, '0, "R7", c, r);
    chk(c == pat(16, 16, '1), "R7", "confident correct bit holds", 128'(c), 128'(pat(16, 16, '1)));
    set_theta(20);
    step(0, 5, 200, 12'hFFF, '0, 0);
    pred(rep(0), 5, '0, "R9", c, r);
    chk(c == pat(24, 24, '1), "R9", "raised threshold trains", 128'(c), 128'(pat(24, 24, '1)));
    step(0, 5, 200, 12'h000, '0, 0);
    pred(rep(0), 5, '0, "R6", c, r);
    chk(c == pat(16, 16, '1), "R6", "sign mismatch trains", 128'(c), 128'(pat(16, 16, '1)));

    step(0, 5, 200, 12'h000, 12'h001, 1);
    pred(rep(0), 5, '0, "R8", c, r);
    chk(c == pat(16, 8, 12'h001), "R8", "suppressed bit not trained", 128'(c), 128'(pat(16, 8, 12'h001)));
    pred(rep(0), 5, 12'h002, "R8", c, r);
    chk(elem(c, 1) == 0 && elem(c, 0) == 16, "R8", "suppressed bit reads 0", 128'(c), 128'(pat(16, 8, 12'h001) & ~(96'hFF << 8)));

    repeat (3) upd({N*ROW_W{1'b0}}, 9, 12'h008, '0, '1, 1);
    pred(rep(0), 9, '0, "R10", c, r);
    chk(r[ROW_W-1:0] == 5'd7, "R10", "table 0 row from history", 128'(r[ROW_W-1:0]), 7);

    pred(rep(4), 9, '0, "R11", ca, ra);
    pred(rep(6), 5, '0, "R11", cb, rb);
    upd(ra, 200, 12'hFFF, ca, '0, 1);
    pred(rep(6), 5, '0, "R11", c, r);
    chk(c == cb, "R11", "other rows untouched", 128'(c), 128'(cb));
    pred(rep(4), 9, '0, "R11", c, r);

    for (int it = 0; it < 400; it++) begin
      logic [(N-1)*ROW_W-1:0] idx; logic [K-1:0] ps, us, t; int slot;
      idx = {$urandom, $urandom};
      slot = $urandom % 16;
      ps = ($urandom % 4 == 0) ? K'($urandom) : '0;
      if ($urandom % 50 == 0) set_theta($urandom % 40);
      pred(idx, slot, ps, "R3", c, r);
      t = K'($urandom);
      us = ($urandom % 3 == 0) ? K'($urandom) : '0;
      if ($urandom % 5 != 0) upd(r, slot, t, c, us, ($urandom % 2) == 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule